// File: doc/BRIEF.md
# Load-Linked Reservation Unit

This block carries out the load-linked step of a load/store pipeline for 32-bit word and 64-bit doubleword accesses. A request gives a virtual address and a size select. The block first checks that the address is naturally aligned for that size.

A misaligned request never reaches memory. Instead the block raises a single-cycle address-error-on-load exception and latches the faulting virtual address into a bad-address register. That latch is skipped while the core runs in debug mode.

An aligned request goes to an external translation port, and the block waits for the physical address. It then reads memory at that address. When the read data arrives, the block records the physical address and the loaded value as the new reservation and sets a link-valid flag. A word is sign-extended to the full value width. The flag stays set until reset or until an external clear arrives. The store-conditional comparison is done elsewhere.

Top module: `ll_unit`

## Requirements
- R1: A word request (`req_dword`=0) is misaligned when `req_vaddr[1:0]` is non-zero. A doubleword request (`req_dword`=1) is misaligned when `req_vaddr[2:0]` is non-zero.
- R2: A misaligned request accepted while idle raises `exc_valid` for exactly the one cycle after the request, with `exc_code`=4. It produces no translation request, no memory read and no `done`, and `busy` stays 0.
- R3: On a misaligned request with `dbg_mode`=0, `badvaddr` takes the request address in the cycle after the request. With `dbg_mode`=1, `badvaddr` keeps its previous value.
- R4: An aligned request sets `busy` and raises `xlat_req_valid` with `xlat_vaddr` equal to the request address. The result on `xlat_paddr` is taken in the cycle where `xlat_rsp_valid` is 1. In the next cycle `mem_rd_valid` is 1, `mem_rd_addr` equals that physical address, `mem_rd_dword` equals the size, and `xlat_req_valid` is 0.
- R5: The read data is taken in the cycle where `mem_rsp_valid` is 1. In the next cycle `done` is 1 for that one cycle only, `busy` is 0, and `link_paddr` holds the translated physical address.
- R6: For a word, `link_value` is bits 31:0 of the read data sign-extended to 64 bits. For a doubleword, `link_value` is the read data unchanged.
- R7: `link_valid` is set by a completed load-linked. It is cleared in the cycle after `clr_link` is 1. If `clr_link` is 1 in the same cycle as the data handshake, the clear wins. `clr_link` leaves `link_paddr` and `link_value` unchanged.
- R8: A request that arrives while `busy`=1 is ignored: it causes no exception and does not change `xlat_vaddr`.
- R9: After reset, `busy`, `done`, `exc_valid`, `exc_code`, `badvaddr`, `link_valid`, `link_paddr` and `link_value` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load-linked request strobe |
| req_dword | input | 1 | Size select: 1 = doubleword, 0 = word |
| req_vaddr | input | 48 | Request virtual address |
| dbg_mode | input | 1 | Core is in debug mode |
| clr_link | input | 1 | Clears the link-valid flag |
| busy | output | 1 | An aligned request is in progress |
| xlat_req_valid | output | 1 | Translation request pending |
| xlat_vaddr | output | 48 | Virtual address to translate |
| xlat_rsp_valid | input | 1 | Translation result valid |
| xlat_rsp_ready | output | 1 | Block can take the translation result |
| xlat_paddr | input | 40 | Translated physical address |
| mem_rd_valid | output | 1 | Memory read pending |
| mem_rd_addr | output | 40 | Physical read address |
| mem_rd_dword | output | 1 | Read size: 1 = doubleword |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block can take the read data |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | One-cycle completion pulse |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_code | output | 5 | Exception code (4 = address error on load) |
| badvaddr | output | 48 | Last faulting virtual address |
| link_valid | output | 1 | Reservation is valid |
| link_paddr | output | 40 | Reserved physical address |
| link_value | output | 64 | Value loaded by the load-linked |

## Verification
The assertions assume a few things about the inputs. The translation and memory responders assert their valid signals only while the matching request is pending. The address and size inputs need no holding after the request cycle. Responses that arrive while no request is pending are outside the checked space. The bench answers each port only after it has seen that port's request signal high, and it varies the response delays. It also sends a deliberate stray request while a request is in progress, and it raises the clear input both on its own and in the same cycle as the data handshake.

// File: rtl/ll_pkg.sv
package ll_pkg;
  typedef enum logic [1:0] {
    LL_IDLE = 2'd0,
    LL_XLAT = 2'd1,
    LL_MEM  = 2'd2
  } ll_state_e;
endpackage

// File: rtl/ll_align_chk.sv
module ll_align_chk #(
  parameter int VA_W = 48
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic            dword,
  output logic            misaligned
);
  // Natural alignment: 4-byte for words, 8-byte for doublewords.
  function automatic logic off_boundary(input logic [2:0] low, input logic dw);
    return dw ? (low != 3'b000) : (low[1:0] != 2'b00);
  endfunction

  assign misaligned = off_boundary(vaddr[2:0], dword);
endmodule

// File: rtl/ll_fsm.sv
module ll_fsm
  import ll_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      misaligned,
  input  logic      xlat_rsp_valid,
  input  logic      mem_rsp_valid,
  output ll_state_e state,
  output logic      acc_start,
  output logic      acc_mis,
  output logic      xlat_fire,
  output logic      mem_fire
);
  logic acc_go;

  assign acc_go    = req_valid && (state == LL_IDLE);
  assign acc_mis   = acc_go && misaligned;
  assign acc_start = acc_go && !misaligned;
  assign xlat_fire = (state == LL_XLAT) && xlat_rsp_valid;
  assign mem_fire  = (state == LL_MEM) && mem_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LL_IDLE;
    end else begin
      unique case (state)
        LL_IDLE: if (acc_start) state <= LL_XLAT;
        LL_XLAT: if (xlat_fire) state <= LL_MEM;
        LL_MEM:  if (mem_fire)  state <= LL_IDLE;
        default: state <= LL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ll_resv_regs.sv
module ll_resv_regs #(
  parameter int VA_W     = 48,
  parameter int PA_W     = 40,
  parameter int DATA_W   = 64,
  parameter int ECODE_W  = 5,
  parameter int EXC_ADEL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_start,
  input  logic              acc_mis,
  input  logic              xlat_fire,
  input  logic              mem_fire,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_dword,
  input  logic              dbg_mode,
  input  logic [PA_W-1:0]   xlat_paddr,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              clr_link,
  output logic [VA_W-1:0]   hold_vaddr,
  output logic              hold_dword,
  output logic [PA_W-1:0]   hold_paddr,
  output logic [VA_W-1:0]   badvaddr,
  output logic              exc_valid,
  output logic [ECODE_W-1:0] exc_code,
  output logic              done,
  output logic              link_valid,
  output logic [PA_W-1:0]   link_paddr,
  output logic [DATA_W-1:0] link_value
);
  localparam int WORD_W = 32;
  localparam int EXT_W  = DATA_W - WORD_W;

  function automatic logic [DATA_W-1:0] link_extend(input logic dw,
                                                    input logic [DATA_W-1:0] d);
    return dw ? d : {{EXT_W{d[WORD_W-1]}}, d[WORD_W-1:0]};
  endfunction

  logic bad_load;
  assign bad_load = acc_mis && !dbg_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vaddr <= '0;
      hold_dword <= 1'b0;
      hold_paddr <= '0;
      badvaddr   <= '0;
      exc_valid  <= 1'b0;
      exc_code   <= '0;
      done       <= 1'b0;
      link_valid <= 1'b0;
      link_paddr <= '0;
      link_value <= '0;
    end else begin
      exc_valid <= acc_mis;
      exc_code  <= acc_mis ? ECODE_W'(EXC_ADEL) : '0;
      done      <= mem_fire;
      if (acc_start) begin
        hold_vaddr <= req_vaddr;
        hold_dword <= req_dword;
      end
      if (bad_load)  badvaddr   <= req_vaddr;
      if (xlat_fire) hold_paddr <= xlat_paddr;
      if (mem_fire) begin
        link_paddr <= hold_paddr;
        link_value <= link_extend(hold_dword, mem_rsp_data);
      end
      if (clr_link)      link_valid <= 1'b0;
      else if (mem_fire) link_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/ll_unit.sv
module ll_unit
  import ll_pkg::*;
#(
  parameter int VA_W     = 48,
  parameter int PA_W     = 40,
  parameter int DATA_W   = 64,
  parameter int ECODE_W  = 5,
  parameter int EXC_ADEL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_dword,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               dbg_mode,
  input  logic               clr_link,
  output logic               busy,
  output logic               xlat_req_valid,
  output logic [VA_W-1:0]    xlat_vaddr,
  input  logic               xlat_rsp_valid,
  output logic               xlat_rsp_ready,
  input  logic [PA_W-1:0]    xlat_paddr,
  output logic               mem_rd_valid,
  output logic [PA_W-1:0]    mem_rd_addr,
  output logic               mem_rd_dword,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [DATA_W-1:0]  mem_rsp_data,
  output logic               done,
  output logic               exc_valid,
  output logic [ECODE_W-1:0] exc_code,
  output logic [VA_W-1:0]    badvaddr,
  output logic               link_valid,
  output logic [PA_W-1:0]    link_paddr,
  output logic [DATA_W-1:0]  link_value
);
  ll_state_e       state;
  logic            misaligned;
  logic            acc_start;
  logic            acc_mis;
  logic            xlat_fire;
  logic            mem_fire;
  logic [VA_W-1:0] hold_vaddr;
  logic            hold_dword;
  logic [PA_W-1:0] hold_paddr;

  ll_align_chk #(.VA_W(VA_W)) u_align (
    .vaddr      (req_vaddr),
    .dword      (req_dword),
    .misaligned (misaligned)
  );

  ll_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .misaligned     (misaligned),
    .xlat_rsp_valid (xlat_rsp_valid),
    .mem_rsp_valid  (mem_rsp_valid),
    .state          (state),
    .acc_start      (acc_start),
    .acc_mis        (acc_mis),
    .xlat_fire      (xlat_fire),
    .mem_fire       (mem_fire)
  );

  ll_resv_regs #(
    .VA_W(VA_W), .PA_W(PA_W), .DATA_W(DATA_W),
    .ECODE_W(ECODE_W), .EXC_ADEL(EXC_ADEL)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_start    (acc_start),
    .acc_mis      (acc_mis),
    .xlat_fire    (xlat_fire),
    .mem_fire     (mem_fire),
    .req_vaddr    (req_vaddr),
    .req_dword    (req_dword),
    .dbg_mode     (dbg_mode),
    .xlat_paddr   (xlat_paddr),
    .mem_rsp_data (mem_rsp_data),
    .clr_link     (clr_link),
    .hold_vaddr   (hold_vaddr),
    .hold_dword   (hold_dword),
    .hold_paddr   (hold_paddr),
    .badvaddr     (badvaddr),
    .exc_valid    (exc_valid),
    .exc_code     (exc_code),
    .done         (done),
    .link_valid   (link_valid),
    .link_paddr   (link_paddr),
    .link_value   (link_value)
  );

  assign busy           = (state != LL_IDLE);
  assign xlat_req_valid = (state == LL_XLAT);
  assign xlat_rsp_ready = (state == LL_XLAT);
  assign xlat_vaddr     = hold_vaddr;
  assign mem_rd_valid   = (state == LL_MEM);
  assign mem_rsp_ready  = (state == LL_MEM);
  assign mem_rd_addr    = hold_paddr;
  assign mem_rd_dword   = hold_dword;
endmodule

// File: rtl/ll_unit_chk.sv
module ll_unit_chk #(
  parameter int VA_W     = 48,
  parameter int PA_W     = 40,
  parameter int DATA_W   = 64,
  parameter int ECODE_W  = 5,
  parameter int EXC_ADEL = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [VA_W-1:0]    req_vaddr,
  input logic               dbg_mode,
  input logic               clr_link,
  input logic               busy,
  input logic               acc_mis,
  input logic               mem_fire,
  input logic               xlat_req_valid,
  input logic               mem_rd_valid,
  input logic [PA_W-1:0]    mem_rd_addr,
  input logic               mem_rd_dword,
  input logic [DATA_W-1:0]  mem_rsp_data,
  input logic               done,
  input logic               exc_valid,
  input logic [ECODE_W-1:0] exc_code,
  input logic [VA_W-1:0]    badvaddr,
  input logic               link_valid,
  input logic [PA_W-1:0]    link_paddr,
  input logic [DATA_W-1:0]  link_value
);
  localparam int WORD_W = 32;

  assert_exc_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mis |=> exc_valid && (exc_code == ECODE_W'(EXC_ADEL)) && !xlat_req_valid && !mem_rd_valid && !done);

  assert_bad_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_mis && !dbg_mode) |=> badvaddr == $past(req_vaddr));

  assert_bad_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_mis && !dbg_mode) |=> $stable(badvaddr));

  assert_port_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xlat_req_valid, mem_rd_valid}));

  assert_link_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire |=> done && !busy && (link_paddr == $past(mem_rd_addr)));

  assert_done_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_fire));

  assert_word_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_fire && !mem_rd_dword) |=>
      (link_value[WORD_W-1:0] == $past(mem_rsp_data[WORD_W-1:0])) &&
      ((link_value[DATA_W-1:WORD_W-1] == '0) || (link_value[DATA_W-1:WORD_W-1] == '1)));

  assert_dword_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_fire && mem_rd_dword) |=> link_value == $past(mem_rsp_data));

  assert_link_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_fire && !clr_link) |=> link_valid);

  assert_link_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_link |=> !link_valid);

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> !exc_valid);
endmodule

bind ll_unit ll_unit_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .DATA_W(DATA_W),
  .ECODE_W(ECODE_W), .EXC_ADEL(EXC_ADEL)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_vaddr      (req_vaddr),
  .dbg_mode       (dbg_mode),
  .clr_link       (clr_link),
  .busy           (busy),
  .acc_mis        (acc_mis),
  .mem_fire       (mem_fire),
  .xlat_req_valid (xlat_req_valid),
  .mem_rd_valid   (mem_rd_valid),
  .mem_rd_addr    (mem_rd_addr),
  .mem_rd_dword   (mem_rd_dword),
  .mem_rsp_data   (mem_rsp_data),
  .done           (done),
  .exc_valid      (exc_valid),
  .exc_code       (exc_code),
  .badvaddr       (badvaddr),
  .link_valid     (link_valid),
  .link_paddr     (link_paddr),
  .link_value     (link_value)
);

// File: tb/ll_unit_bench.sv
module ll_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_dword = 1'b0, dbg_mode = 1'b0, clr_link = 1'b0;
  logic [47:0] req_vaddr = '0;
  logic        xlat_rsp_valid = 1'b0, mem_rsp_valid = 1'b0;
  logic [39:0] xlat_paddr = '0;
  logic [63:0] mem_rsp_data = '0;
  logic        busy, xlat_req_valid, xlat_rsp_ready, mem_rd_valid, mem_rd_dword, mem_rsp_ready;
  logic        done, exc_valid, link_valid;
  logic [47:0] xlat_vaddr, badvaddr;
  logic [39:0] mem_rd_addr, link_paddr;
  logic [4:0]  exc_code;
  logic [63:0] link_value;

  always #(CLK_PERIOD/2) clk = ~clk;

  ll_unit u_ll_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dword(req_dword),
    .req_vaddr(req_vaddr), .dbg_mode(dbg_mode), .clr_link(clr_link), .busy(busy),
    .xlat_req_valid(xlat_req_valid), .xlat_vaddr(xlat_vaddr),
    .xlat_rsp_valid(xlat_rsp_valid), .xlat_rsp_ready(xlat_rsp_ready), .xlat_paddr(xlat_paddr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_dword(mem_rd_dword),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .done(done), .exc_valid(exc_valid), .exc_code(exc_code), .badvaddr(badvaddr),
    .link_valid(link_valid), .link_paddr(link_paddr), .link_value(link_value)
  );

  typedef struct {
    logic        is_exc;
    logic [47:0] bad;
    logic [39:0] pa;
    logic [63:0] val;
    logic        lv;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_bad = 0;
  logic [47:0] model_bad = '0;
  logic [39:0] model_pa = '0;
  logic [63:0] model_val = '0;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per exception or completion pulse.
  always @(negedge clk) begin
    if (rst_n && (exc_valid || done)) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2/R5 unexpected pulse", {62'd0, exc_valid, done}, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.is_exc) begin
          chk(exc_valid && !done, "R2 exception pulse", {62'd0, exc_valid, done}, 64'd2);
          chk(exc_code == 5'd4, "R2 exc_code", 64'(exc_code), 64'd4);
          chk(badvaddr == e.bad, "R3 badvaddr", 64'(badvaddr), 64'(e.bad));
        end else begin
          chk(done && !exc_valid, "R5 done pulse", {62'd0, exc_valid, done}, 64'd1);
          chk(link_paddr == e.pa, "R5 link_paddr", 64'(link_paddr), 64'(e.pa));
          chk(link_value == e.val, "R6 link_value", link_value, e.val);
          chk(link_valid == e.lv, "R7 link_valid", 64'(link_valid), 64'(e.lv));
        end
      end
    end
  end

  task automatic do_ll(input logic [47:0] va, input logic dw, input logic dbg,
                       input logic [39:0] pa, input logic [63:0] rd,
                       input int xd, input int md, input logic poke, input logic clr_mem);
    logic mis;
    exp_t e;
    mis = dw ? (va[2:0] != 3'd0) : (va[1:0] != 2'd0);
    e.is_exc = mis;
    e.bad    = (mis && !dbg) ? va : model_bad;
    e.pa     = pa;
    e.val    = dw ? rd : {{32{rd[31]}}, rd[31:0]};
    e.lv     = !clr_mem;
    sb.push_back(e);
    model_bad = e.bad;
    req_valid = 1'b1; req_vaddr = va; req_dword = dw; dbg_mode = dbg;
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = ~va; dbg_mode = 1'b0;
    if (mis) begin
      chk(!xlat_req_valid && !mem_rd_valid && !busy, "R1/R2 no access on misaligned",
          {61'd0, xlat_req_valid, mem_rd_valid, busy}, 64'd0);
      @(negedge clk);
      chk(!exc_valid, "R2 exc one cycle", 64'(exc_valid), 64'd0);
    end else begin
      chk(xlat_req_valid && xlat_rsp_ready && busy, "R1/R4 translation request",
          {61'd0, xlat_req_valid, xlat_rsp_ready, busy}, 64'd7);
      chk(xlat_vaddr == va, "R4 xlat_vaddr", 64'(xlat_vaddr), 64'(va));
      if (poke) begin
        req_valid = 1'b1; req_vaddr = va ^ 48'h123; req_dword = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(xlat_vaddr == va, "R8 ignored while busy", 64'(xlat_vaddr), 64'(va));
      end
      repeat (xd) @(negedge clk);
      xlat_rsp_valid = 1'b1; xlat_paddr = pa;
      @(negedge clk);
      xlat_rsp_valid = 1'b0; xlat_paddr = ~pa;
      chk(mem_rd_valid && mem_rsp_ready && !xlat_req_valid, "R4 memory read issued",
          {61'd0, mem_rd_valid, mem_rsp_ready, xlat_req_valid}, 64'd6);
      chk(mem_rd_addr == pa, "R4 mem_rd_addr", 64'(mem_rd_addr), 64'(pa));
      chk(mem_rd_dword == dw, "R4 mem_rd_dword", 64'(mem_rd_dword), 64'(dw));
      repeat (md) @(negedge clk);
      mem_rsp_valid = 1'b1; mem_rsp_data = rd; clr_link = clr_mem;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = ~rd; clr_link = 1'b0;
      chk(!busy, "R5 idle after done", 64'(busy), 64'd0);
      model_pa = pa; model_val = e.val;
      @(negedge clk);
      chk(!done, "R5 done one cycle", 64'(done), 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, exc_valid, exc_code, link_valid} == 9'd0, "R9 reset flags",
        64'({busy, done, exc_valid, exc_code, link_valid}), 64'd0);
    chk(badvaddr == '0 && link_paddr == '0 && link_value == '0, "R9 reset registers",
        64'(link_value), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    do_ll(48'h0000_1234_5670, 1'b0, 1'b0, 40'h00_8000_1000, 64'hAAAA_5555_1234_5678, 0, 0, 1'b0, 1'b0);
    do_ll(48'h0000_0000_0104, 1'b0, 1'b0, 40'h12_3456_7894, 64'hDEAD_BEEF_8000_0001, 2, 3, 1'b0, 1'b0);
    do_ll(48'h7FFF_FFFF_FFF8, 1'b1, 1'b0, 40'hFF_FFFF_FFF8, 64'h8123_4567_89AB_CDEF, 1, 0, 1'b0, 1'b0);
    do_ll(48'h0000_0000_2002, 1'b0, 1'b0, 40'h0, 64'h0, 0, 0, 1'b0, 1'b0);
    do_ll(48'h0000_0000_3004, 1'b1, 1'b0, 40'h0, 64'h0, 0, 0, 1'b0, 1'b0);
    do_ll(48'h0000_0000_4001, 1'b1, 1'b1, 40'h0, 64'h0, 0, 0, 1'b0, 1'b0);
    do_ll(48'hABCD_0000_0003, 1'b0, 1'b1, 40'h0, 64'h0, 0, 0, 1'b0, 1'b0);
    do_ll(48'h0000_0000_5001, 1'b1, 1'b0, 40'h0, 64'h0, 0, 0, 1'b0, 1'b0);
    // R7: standalone clear keeps the reservation contents
    clr_link = 1'b1;
    @(negedge clk);
    clr_link = 1'b0;
    chk(!link_valid, "R7 clear", 64'(link_valid), 64'd0);
    chk(link_paddr == model_pa && link_value == model_val, "R7 clear keeps data",
        64'(link_paddr), 64'(model_pa));
    do_ll(48'h0000_0000_6008, 1'b1, 1'b0, 40'h01_0000_0008, 64'h0000_0000_FFFF_FFFF, 3, 1, 1'b1, 1'b0);
    do_ll(48'h0000_0000_700C, 1'b0, 1'b0, 40'h02_0000_000C, 64'h1111_2222_7FFF_FFFF, 0, 2, 1'b0, 1'b1);
    chk(!link_valid, "R7 clear wins over completion", 64'(link_valid), 64'd0);
    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R2/R5 missing pulse", 64'(sb.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule